// File: doc/BRIEF.md
# Selectable-Source Prescaled 16-bit Timer Counter

This block is the counting core of a general-purpose timer. It runs entirely on the peripheral clock. A two-bit field picks what drives the count: the peripheral clock itself, a 32.768 kHz subclock, a dedicated external clock pin, or the first compare output of a neighbouring timer. Every source other than the peripheral clock is brought into the peripheral clock domain through a two-flop synchronizer. A rising-edge detector then turns each low-to-high transition into a one-cycle event.

The events pass through a divider whose ratio is a power of two, chosen by a three-bit code. Every time the divider completes, the 16-bit counter advances by one. The count is presented as separate upper and lower bytes. A sticky flag records each wrap from 0xFFFF to zero, and software clears it with a write-one pulse.

Two parameters shape each instance. One picks the divider table: the standard table tops out at 128, and the long table tops out at 32768, which turns the subclock into a one-second tick. The other decides whether the neighbour-timer source exists, so that timers can be cascaded.

Top module: `tick_counter16`

## Requirements
- R1: After reset the count bytes are both zero and the overflow flag is low.
- R2: With source code 0 (peripheral clock) and divider code 0, the count rises by exactly one on every peripheral clock edge.
- R3: Divider codes 0 to 6 divide the selected source events by 2 to the power of the code, so code 3 gives one count per 8 events.
- R4: Divider code 7 divides by 128 when LONG_DIV is 0, and by 32768 when LONG_DIV is 1.
- R5: With source code 2 the count advances once for each rising edge seen on the external clock pin. The pin is synchronized through two flops, and levels held across many cycles add no further counts.
- R6: With source code 1 the subclock input is the event source, and it is divided in the same way as any other source.
- R7: Source code 3 counts rising edges of the neighbour compare input when HAS_CASCADE is 1. When HAS_CASCADE is 0, code 3 never advances the count.
- R8: When the count wraps from 0xFFFF to 0 the overflow flag goes high, and it stays high until it is cleared.
- R9: A one on the clear input lowers the flag on the next edge. If a wrap happens in the same cycle as the clear, the flag stays high.
- R10: Any change of the source or divider code restarts the divider, so the first count after the change comes exactly one full divider period of events later.
- R11: cnt_hi_o carries count bits 15..8 and cnt_lo_o carries bits 7..0, and the count only ever steps by +1 modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock; all state is on this clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sub_clk_i | input | 1 | 32.768 kHz subclock, sampled |
| ext_clk_i | input | 1 | External clock pin, sampled |
| nbr_cmp_i | input | 1 | Neighbour timer compare output, sampled |
| src_sel_i | input | 2 | Source: 0 peripheral clock, 1 subclock, 2 external pin, 3 neighbour |
| div_sel_i | input | 3 | Divider code, indexes the instance's table |
| ovf_clr_i | input | 1 | Write-one-to-clear for the overflow flag |
| cnt_hi_o | output | 8 | Count bits 15..8 |
| cnt_lo_o | output | 8 | Count bits 7..0 |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The hardest case to reach is a wrap that lands in the very cycle the clear pulse is applied. It can only be reached by running the counter through its whole 16-bit range. The stimulus selects the peripheral clock with no division and reads the current count. From that value it works out how many edges remain until 0xFFFF, waits exactly that many, and raises the clear for the single cycle whose closing edge wraps. The divider restart is reached in a similar way: the divide-by-8 divider is stopped part-way through its period and the code is switched, and the bench then checks that the first count arrives exactly four edges later, not sooner.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        SRC_PCLK = 2'd0,
        SRC_SUB  = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_NBR  = 2'd3
    } tmr_src_e;

    localparam int unsigned DIV_CODE_W = 3;
    localparam int unsigned N_SAMPLED  = 3;

    // log2 of the division ratio for a code; the top code depends on the table
    function automatic int unsigned div_log2(input logic [DIV_CODE_W-1:0] code,
                                             input int unsigned top_log2);
        int unsigned r;
        if (code == {DIV_CODE_W{1'b1}}) r = top_log2;
        else                            r = int'(code);
        return r;
    endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);
    localparam int unsigned SH_W = STAGES + 1;

    typedef struct packed {
        logic [SH_W-1:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[SH_W-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // last synchronized stage high while the delayed copy is still low
    assign rise_o = st_q.sh[STAGES-1] & ~st_q.sh[STAGES];

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter bit LONG_DIV = 1'b0
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  ev_i,
    input  logic                  restart_i,
    input  logic [DIV_CODE_W-1:0] div_sel_i,
    output logic                  tick_o
);
    localparam int unsigned TOP_LOG2 = LONG_DIV ? 15 : 7;
    localparam int unsigned PW       = TOP_LOG2;

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_st_t;

    pre_st_t     st_d, st_q;
    logic [PW:0] span;
    logic [PW-1:0] limit;

    always_comb begin
        span  = (PW+1)'(1) << div_log2(div_sel_i, TOP_LOG2);
        limit = PW'(span - (PW+1)'(1));
    end

    always_comb begin
        st_d   = st_q;
        tick_o = 1'b0;
        if (restart_i) begin
            st_d.cnt = '0;
        end else if (ev_i) begin
            if (st_q.cnt == limit) begin
                tick_o   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + PW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/tick_counter16.sv
module tick_counter16
    import tmr_pkg::*;
#(
    parameter bit          LONG_DIV    = 1'b0,
    parameter bit          HAS_CASCADE = 1'b1,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = 16
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  sub_clk_i,
    input  logic                  ext_clk_i,
    input  logic                  nbr_cmp_i,
    input  logic [1:0]            src_sel_i,
    input  logic [DIV_CODE_W-1:0] div_sel_i,
    input  logic                  ovf_clr_i,
    output logic [7:0]            cnt_hi_o,
    output logic [7:0]            cnt_lo_o,
    output logic                  ovf_o
);
    localparam int unsigned CFG_W = 2 + DIV_CODE_W;
    localparam int unsigned HALF  = CNT_W / 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic [CFG_W-1:0] cfg;
    } top_st_t;

    top_st_t              st_d, st_q;
    logic [N_SAMPLED-1:0] raw_in;
    logic [N_SAMPLED-1:0] rise;
    logic                 ev;
    logic                 restart;
    logic                 tick;
    tmr_src_e             src;

    assign raw_in = {nbr_cmp_i, ext_clk_i, sub_clk_i};
    assign src    = tmr_src_e'(src_sel_i);

    // one synchronizer per sampled source; the neighbour one only when cascading
    for (genvar g = 0; g < N_SAMPLED; g++) begin : g_sync
        if (g == N_SAMPLED - 1 && !HAS_CASCADE) begin : g_none
            assign rise[g] = 1'b0;
        end else begin : g_inst
            tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .async_i(raw_in[g]),
                .rise_o (rise[g])
            );
        end
    end

    always_comb begin
        unique case (src)
            SRC_PCLK: ev = 1'b1;
            SRC_SUB:  ev = rise[0];
            SRC_EXT:  ev = rise[1];
            SRC_NBR:  ev = rise[2];
            default:  ev = 1'b0;
        endcase
    end

    assign restart = {src_sel_i, div_sel_i} != st_q.cfg;

    tmr_prescaler #(.LONG_DIV(LONG_DIV)) u_pre (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ev_i     (ev),
        .restart_i(restart),
        .div_sel_i(div_sel_i),
        .tick_o   (tick)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cfg = {src_sel_i, div_sel_i};
        if (tick) st_d.cnt = st_q.cnt + CNT_W'(1);
        // a wrap sets the flag even when a clear arrives in the same cycle
        st_d.ovf = (tick && (&st_q.cnt)) || (st_q.ovf && !ovf_clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_hi_o = st_q.cnt[CNT_W-1:HALF];
    assign cnt_lo_o = st_q.cnt[HALF-1:0];
    assign ovf_o    = st_q.ovf;

endmodule

// File: rtl/tick_counter16_chk.sv
module tick_counter16_chk #(
    parameter bit HAS_CASCADE = 1'b1
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] src_sel_i,
    input logic       ovf_clr_i,
    input logic [7:0] cnt_hi_o,
    input logic [7:0] cnt_lo_o,
    input logic       ovf_o
);
    logic [15:0] cnt;
    assign cnt = {cnt_hi_o, cnt_lo_o};

    // R1
    rst_state_chk: assert property (@(posedge clk_i) !rst_ni |=> (cnt == 16'd0 && !ovf_o));

    // R11
    step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 16'd1));

    // R8
    wrap_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(cnt) == 16'hFFFF && cnt == 16'd0) |-> ovf_o);

    // R8
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(ovf_o) && !$past(ovf_clr_i)) |-> ovf_o);

    // R9
    clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(ovf_clr_i) && $past(cnt) != 16'hFFFF) |-> !ovf_o);

    // R7
    no_cascade_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!HAS_CASCADE && $past(src_sel_i) == 2'd3) |-> $stable(cnt));

endmodule

bind tick_counter16 tick_counter16_chk #(.HAS_CASCADE(HAS_CASCADE)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_sel_i(src_sel_i),
    .ovf_clr_i(ovf_clr_i),
    .cnt_hi_o (cnt_hi_o),
    .cnt_lo_o (cnt_lo_o),
    .ovf_o    (ovf_o)
);

// File: tb/tick_counter16_test.sv
module tick_counter16_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sub_clk = 1'b0;
    logic       ext_clk = 1'b0;
    logic       nbr_cmp = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [2:0] div_sel = 3'd0;
    logic       ovf_clr = 1'b0;

    logic [7:0] a_hi, a_lo, b_hi, b_lo;
    logic       a_ovf, b_ovf;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        int    sel;   // 0: uut count, 1: uut flag, 2: uut_long count
        int    exp;
        string tag;
    } sb_item_t;

    sb_item_t sb[$];

    // 250 MHz peripheral clock: 4-unit period
    always #2 clk = ~clk;

    // standard table, no neighbour source
    tick_counter16 #(.LONG_DIV(1'b0), .HAS_CASCADE(1'b0)) uut (
        .clk_i(clk), .rst_ni(rst_n), .sub_clk_i(sub_clk), .ext_clk_i(ext_clk),
        .nbr_cmp_i(nbr_cmp), .src_sel_i(src_sel), .div_sel_i(div_sel),
        .ovf_clr_i(ovf_clr), .cnt_hi_o(a_hi), .cnt_lo_o(a_lo), .ovf_o(a_ovf)
    );

    // long table, neighbour source present
    tick_counter16 #(.LONG_DIV(1'b1), .HAS_CASCADE(1'b1)) uut_long (
        .clk_i(clk), .rst_ni(rst_n), .sub_clk_i(sub_clk), .ext_clk_i(ext_clk),
        .nbr_cmp_i(nbr_cmp), .src_sel_i(src_sel), .div_sel_i(div_sel),
        .ovf_clr_i(ovf_clr), .cnt_hi_o(b_hi), .cnt_lo_o(b_lo), .ovf_o(b_ovf)
    );

    function automatic int read_a();
        return int'({a_hi, a_lo});
    endfunction

    function automatic int read_b();
        return int'({b_hi, b_lo});
    endfunction

    task automatic expect_item(input int sel, input int exp, input string tag);
        sb_item_t it;
        it.sel = sel;
        it.exp = exp & 32'hFFFF;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: compares every queued expectation half a cycle after it is queued
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            sb_item_t it;
            int act;
            it = sb.pop_front();
            case (it.sel)
                0:       act = read_a();
                1:       act = int'(a_ovf);
                default: act = read_b();
            endcase
            n_total++;
            if (act != it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
            end
        end
    end

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic set_cfg(input logic [1:0] s, input logic [2:0] d,
                           output int c_a, output int c_b);
        @(negedge clk);
        src_sel = s;
        div_sel = d;
        @(posedge clk);
        #1;
        c_a = read_a();
        c_b = read_b();
    endtask

    task automatic pulses(input int which, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            case (which)
                0:       sub_clk = 1'b1;
                1:       ext_clk = 1'b1;
                default: nbr_cmp = 1'b1;
            endcase
            @(negedge clk);
            @(negedge clk);
            sub_clk = 1'b0;
            ext_clk = 1'b0;
            nbr_cmp = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        int ca, cb, rem;

        repeat (3) @(posedge clk);
        #1;
        expect_item(0, 0, "R1 count after reset");
        expect_item(1, 0, "R1 flag after reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R2: peripheral clock, divide by one
        set_cfg(2'd0, 3'd0, ca, cb);
        edges(10);
        expect_item(0, ca + 10, "R2 count every edge");
        expect_item(2, cb + 10, "R2 count every edge long");
        // R11: byte split seen across a carry into the upper byte
        edges(300);
        expect_item(0, ca + 310, "R11 upper and lower bytes");

        // R3 / R10: divide by 8
        set_cfg(2'd0, 3'd3, ca, cb);
        edges(7);
        expect_item(0, ca, "R10 no early count after change");
        edges(1);
        expect_item(0, ca + 1, "R10 first count after 8 edges");
        edges(16);
        expect_item(0, ca + 3, "R3 divide by 8");
        expect_item(2, cb + 3, "R3 divide by 8 long");

        // R10: switch code mid-period, divider restarts
        edges(3);
        set_cfg(2'd0, 3'd2, ca, cb);
        edges(3);
        expect_item(0, ca, "R10 restart no early count");
        edges(1);
        expect_item(0, ca + 1, "R10 restart first count after 4");

        // R5: external pin, ten rising edges
        set_cfg(2'd2, 3'd0, ca, cb);
        pulses(1, 10);
        edges(4);
        expect_item(0, ca + 10, "R5 external edges counted");
        edges(20);
        expect_item(0, ca + 10, "R5 idle pin adds nothing");

        // R6: subclock divided by 2
        set_cfg(2'd1, 3'd1, ca, cb);
        pulses(0, 10);
        edges(4);
        expect_item(0, ca + 5, "R6 subclock divide by 2");
        expect_item(2, cb + 5, "R6 subclock divide by 2 long");

        // R7: neighbour source
        set_cfg(2'd3, 3'd0, ca, cb);
        pulses(2, 6);
        edges(4);
        expect_item(0, ca, "R7 no cascade ignores neighbour");
        expect_item(2, cb + 6, "R7 cascade counts neighbour");

        // R4: top code on both tables
        set_cfg(2'd0, 3'd7, ca, cb);
        edges(127);
        expect_item(0, ca, "R4 standard top before 128");
        edges(1);
        expect_item(0, ca + 1, "R4 standard top at 128");
        edges(32768 - 128 - 1);
        expect_item(2, cb, "R4 long top before 32768");
        edges(1);
        expect_item(2, cb + 1, "R4 long top at 32768");
        expect_item(0, ca + 256, "R4 standard top 256 periods");

        // R8: run to the wrap
        set_cfg(2'd0, 3'd0, ca, cb);
        rem = 16'hFFFF - ca;
        if (rem > 0) edges(rem);
        expect_item(0, 16'hFFFF, "R8 count at maximum");
        expect_item(1, 0, "R8 flag low before wrap");
        edges(1);
        expect_item(0, 0, "R8 wrap to zero");
        expect_item(1, 1, "R8 flag set on wrap");
        edges(5);
        expect_item(1, 1, "R8 flag sticky");

        // R9: clear
        @(negedge clk);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        expect_item(1, 0, "R9 clear lowers flag");

        // R9: wrap in the clear cycle, flag must stay set
        edges(1);
        rem = 16'hFFFF - read_a();
        if (rem > 0) edges(rem);
        expect_item(0, 16'hFFFF, "R9 count at maximum again");
        @(negedge clk);
        ovf_clr = 1'b1;
        @(posedge clk);
        #1;
        expect_item(0, 0, "R9 second wrap");
        expect_item(1, 1, "R9 wrap beats clear");
        @(negedge clk);
        ovf_clr = 1'b0;
        edges(2);

        done = 1'b1;
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule